// File: doc/BRIEF.md
# Switch CPU-Port Extraction Header Parser

This block sits on the receive side of a host attached to a switch port that has been configured as the CPU port. The switch sends each frame with a prefix (optional) and then a 28-byte internal frame header in front of it. The parser reads one byte per beat from an AXI4-Stream input. It checks the prefix bytes and captures the header as a 224-bit big-endian vector. From that vector it decodes the source port, QoS class, VLAN TCI and tag type.

Tag popping in the switch can leave 0, 4 or 8 filler bytes between the header and the real destination MAC. The parser removes them. It then passes the Ethernet frame through to an output stream, byte for byte. The decoded metadata is presented as sideband, marked by a flag on the first output beat.

A two-bit select input picks which prefix is expected. It is read only on the first byte of each frame. A bad prefix byte, or a frame that ends before its payload starts, raises a one-cycle error pulse, and the frame is discarded.

Top module: `exthdr_rx_parser`

## Requirements
- R1: `pfx_sel` chooses the expected prefix: 0 = none, 1 = short, 2 = long, and 3 is treated as none. The value is sampled only when a frame's first byte is accepted. Changes later in the same frame have no effect on that frame.
- R2: With the long prefix, the first 16 bytes must be, in order: FF FF FF FF FF FF FE FF FF FF FF FF 88 80 00 11.
- R3: With the short prefix, the first 4 bytes must be 88 80 00 11.
- R4: The 28 bytes after the prefix form a 224-bit vector. The first byte holds bits 223:216 and the last byte holds bits 7:0. The vector is decoded as follows: source port = bits 143:140, QoS class = bits 96:94, VLAN TCI = bits 118:103, tag type = bit 119. These values are valid on the output beat that has `m_first` high.
- R5: `m_tpid` is 16'h88A8 when the tag type bit is 1 and 16'h8100 when it is 0.
- R6: Let pop count = bits 147:146 and ethertype offset = bits 145:144. If both are 0, the 8 bytes after the header are dropped. If pop count is 3, 4 bytes are dropped. In every other case, no bytes are dropped.
- R7: Every byte after the header and gap is forwarded unchanged and in order. `m_tlast` is a copy of `s_tlast`. `m_first` is high only on the first forwarded beat of a frame. After a beat with `m_tlast`, no output beat appears in the next cycle.
- R8: While `m_tready` is low during forwarding, `s_tready` is low. A stalled output beat keeps its data, and no byte is lost or duplicated.
- R9: A prefix byte that does not match raises `err_pulse` for one cycle, in the cycle after that byte is accepted. The remainder of the frame, up to and including `s_tlast`, is consumed and produces no output.
- R10: If `s_tlast` arrives on a prefix, header or gap byte, `err_pulse` is raised for one cycle, nothing is forwarded, and the next byte is treated as the start of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfx_sel | input | 2 | Prefix format select, sampled at frame start |
| s_tdata | input | 8 | Input stream byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted |
| s_tlast | input | 1 | Last byte of the input frame |
| m_tdata | output | 8 | Forwarded Ethernet byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Last byte of the forwarded frame |
| m_first | output | 1 | First forwarded beat; the metadata below is valid with it |
| m_src_port | output | 4 | Decoded source port |
| m_qos | output | 3 | Decoded QoS class |
| m_tpid | output | 16 | TPID derived from the tag type |
| m_tci | output | 16 | Decoded VLAN TCI |
| err_pulse | output | 1 | One-cycle malformed-frame flag |

## Verification
The stall checks assume that the upstream source follows AXI4-Stream rules: once it offers a byte, it holds `s_tvalid` and `s_tdata` until the byte is taken. The stimulus only inserts idle bubbles when no byte is pending, so this assumption always holds. The checks also expect `m_tready` to be freely variable. The bench toggles `m_tready` on a fixed pattern that is independent of the parser's state, which covers stalls landing on the first beat, on middle beats and on the last beat of a frame.

// File: rtl/exthdr_pkg.sv
package exthdr_pkg;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_PFX   = 3'd1,
    ST_HDR   = 3'd2,
    ST_GAP   = 3'd3,
    ST_DATA  = 3'd4,
    ST_DROP  = 3'd5
  } rx_state_t;

  typedef enum logic [1:0] {
    FMT_NONE  = 2'd0,
    FMT_SHORT = 2'd1,
    FMT_LONG  = 2'd2,
    FMT_RSVD  = 2'd3
  } pfx_fmt_t;

  localparam int LONG_PFX_BYTES  = 16;
  localparam int SHORT_PFX_BYTES = 4;

  // bit positions (LSB of each field) inside the captured header vector
  localparam int QOS_LSB = 94;
  localparam int QOS_W   = 3;
  localparam int TCI_LSB = 103;
  localparam int TCI_W   = 16;
  localparam int TAG_LSB = 119;
  localparam int SRC_LSB = 140;
  localparam int SRC_W   = 4;
  localparam int OFS_LSB = 144;
  localparam int POP_LSB = 146;
  localparam int TAGCNT_W = 2;

  localparam logic [15:0] TPID_CTAG = 16'h8100;
  localparam logic [15:0] TPID_STAG = 16'h88A8;

  typedef struct packed {
    logic [SRC_W-1:0] src_port;
    logic [QOS_W-1:0] qos;
    logic             tag_s;
    logic [TCI_W-1:0] tci;
  } hdr_meta_t;

endpackage

// File: rtl/exthdr_pfx_ref.sv
module exthdr_pfx_ref
  import exthdr_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  pfx_fmt_t         fmt,
  input  logic [CNT_W-1:0] idx,
  output logic [7:0]       exp_byte,
  output logic [CNT_W-1:0] pfx_len
);

  localparam logic [CNT_W-1:0] SHORT_SKIP = CNT_W'(LONG_PFX_BYTES - SHORT_PFX_BYTES);

  logic [CNT_W-1:0] lidx;

  // the short prefix equals the tail of the long one
  always_comb begin
    if (fmt == FMT_SHORT) lidx = idx + SHORT_SKIP;
    else                  lidx = idx;
  end

  always_comb begin
    unique case (fmt)
      FMT_LONG:  pfx_len = CNT_W'(LONG_PFX_BYTES);
      FMT_SHORT: pfx_len = CNT_W'(SHORT_PFX_BYTES);
      default:   pfx_len = '0;
    endcase
  end

  always_comb begin
    if (lidx == CNT_W'(6))       exp_byte = 8'hFE;
    else if (lidx == CNT_W'(12)) exp_byte = 8'h88;
    else if (lidx == CNT_W'(13)) exp_byte = 8'h80;
    else if (lidx == CNT_W'(14)) exp_byte = 8'h00;
    else if (lidx == CNT_W'(15)) exp_byte = 8'h11;
    else                         exp_byte = 8'hFF;
  end

endmodule

// File: rtl/exthdr_field_dec.sv
module exthdr_field_dec
  import exthdr_pkg::*;
#(
  parameter int HDR_BITS = 224
) (
  input  logic [HDR_BITS-1:0] vec,
  output hdr_meta_t           meta
);

  always_comb begin
    meta.src_port = vec[SRC_LSB +: SRC_W];
    meta.qos      = vec[QOS_LSB +: QOS_W];
    meta.tag_s    = vec[TAG_LSB];
    meta.tci      = vec[TCI_LSB +: TCI_W];
  end

  logic unused_bits;
  assign unused_bits = ^{vec[HDR_BITS-1:SRC_LSB+SRC_W],
                         vec[SRC_LSB-1:TAG_LSB+1],
                         vec[TCI_LSB-1:QOS_LSB+QOS_W],
                         vec[QOS_LSB-1:0]};

endmodule

// File: rtl/exthdr_gap_calc.sv
module exthdr_gap_calc
  import exthdr_pkg::*;
#(
  parameter int W          = 5,
  parameter int GAP_TWO    = 8,
  parameter int GAP_ONE    = 4
) (
  input  logic [TAGCNT_W-1:0] pop_cnt,
  input  logic [TAGCNT_W-1:0] eth_ofs,
  output logic [W-1:0]        gap_bytes
);

  always_comb begin
    if (pop_cnt == '0 && eth_ofs == '0) gap_bytes = W'(GAP_TWO);
    else if (pop_cnt == '1)             gap_bytes = W'(GAP_ONE);
    else                                gap_bytes = '0;
  end

endmodule

// File: rtl/exthdr_rx_parser.sv
module exthdr_rx_parser
  import exthdr_pkg::*;
#(
  parameter int HDR_BYTES = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  pfx_sel,
  input  logic [7:0]  s_tdata,
  input  logic        s_tvalid,
  output logic        s_tready,
  input  logic        s_tlast,
  output logic [7:0]  m_tdata,
  output logic        m_tvalid,
  input  logic        m_tready,
  output logic        m_tlast,
  output logic        m_first,
  output logic [3:0]  m_src_port,
  output logic [2:0]  m_qos,
  output logic [15:0] m_tpid,
  output logic [15:0] m_tci,
  output logic        err_pulse
);

  localparam int HDR_BITS = HDR_BYTES * 8;
  localparam int CNT_MAX  = (HDR_BYTES > LONG_PFX_BYTES) ? HDR_BYTES : LONG_PFX_BYTES;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BYTES - 1);

  rx_state_t        state_q, state_d;
  pfx_fmt_t         fmt_q, fmt_d, eff_fmt;
  logic [CNT_W-1:0] cnt_q, cnt_d, gap_q, gap_d, cur_idx;
  logic [CNT_W-1:0] pfx_len, pfx_last, gap_nx;
  logic [7:0]       exp_byte;
  logic             first_q, first_d, err_q, err_d;
  logic             fmt_en, hdr_en, acc, in_pfx;
  logic [HDR_BITS-1:0] hdr_q, hdr_nx;
  hdr_meta_t        meta;

  // format and byte index seen by the current input byte
  assign eff_fmt  = (state_q == ST_START) ? pfx_fmt_t'(pfx_sel) : fmt_q;
  assign cur_idx  = (state_q == ST_START) ? '0 : cnt_q;
  assign pfx_last = pfx_len - 1'b1;
  assign in_pfx   = (state_q == ST_PFX) || ((state_q == ST_START) && (pfx_len != '0));
  assign hdr_nx   = {hdr_q[HDR_BITS-9:0], s_tdata};

  exthdr_pfx_ref #(.CNT_W(CNT_W)) i_pfx_ref (
    .fmt      (eff_fmt),
    .idx      (cur_idx),
    .exp_byte (exp_byte),
    .pfx_len  (pfx_len)
  );

  // gap size taken from the vector as it will be after this byte
  exthdr_gap_calc #(.W(CNT_W)) i_gap_calc (
    .pop_cnt   (hdr_nx[POP_LSB +: TAGCNT_W]),
    .eth_ofs   (hdr_nx[OFS_LSB +: TAGCNT_W]),
    .gap_bytes (gap_nx)
  );

  exthdr_field_dec #(.HDR_BITS(HDR_BITS)) i_field_dec (
    .vec  (hdr_q),
    .meta (meta)
  );

  // stream handshake: pass-through while forwarding, sink otherwise
  assign s_tready = (state_q == ST_DATA) ? m_tready : 1'b1;
  assign acc      = s_tvalid && s_tready;
  assign m_tvalid = (state_q == ST_DATA) && s_tvalid;
  assign m_tdata  = s_tdata;
  assign m_tlast  = s_tlast;
  assign m_first  = (state_q == ST_DATA) && first_q;

  assign m_src_port = meta.src_port;
  assign m_qos      = meta.qos;
  assign m_tci      = meta.tci;
  assign m_tpid     = meta.tag_s ? TPID_STAG : TPID_CTAG;
  assign err_pulse  = err_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    gap_d   = gap_q;
    fmt_d   = fmt_q;
    first_d = first_q;
    err_d   = 1'b0;
    fmt_en  = 1'b0;
    hdr_en  = 1'b0;
    if (acc) begin
      unique case (state_q)
        ST_START, ST_PFX, ST_HDR: begin
          if (state_q == ST_START) begin
            fmt_en = 1'b1;
            fmt_d  = eff_fmt;
          end
          if (in_pfx) begin
            if ((s_tdata != exp_byte) || s_tlast) begin
              err_d   = 1'b1;
              state_d = s_tlast ? ST_START : ST_DROP;
            end else if (cur_idx == pfx_last) begin
              state_d = ST_HDR;
              cnt_d   = '0;
            end else begin
              state_d = ST_PFX;
              cnt_d   = cur_idx + 1'b1;
            end
          end else begin
            hdr_en = 1'b1;
            if (s_tlast) begin
              err_d   = 1'b1;
              state_d = ST_START;
            end else if (cur_idx == HDR_LAST) begin
              cnt_d = '0;
              if (gap_nx == '0) begin
                state_d = ST_DATA;
                first_d = 1'b1;
              end else begin
                state_d = ST_GAP;
                gap_d   = gap_nx;
              end
            end else begin
              state_d = ST_HDR;
              cnt_d   = cur_idx + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (s_tlast) begin
            err_d   = 1'b1;
            state_d = ST_START;
          end else if (cnt_q == gap_q - 1'b1) begin
            state_d = ST_DATA;
            first_d = 1'b1;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          first_d = 1'b0;
          if (s_tlast) state_d = ST_START;
        end
        ST_DROP: begin
          if (s_tlast) state_d = ST_START;
        end
        default: state_d = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      cnt_q   <= '0;
      gap_q   <= '0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
      first_q <= first_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fmt_q <= FMT_NONE;
    else if (fmt_en) fmt_q <= fmt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hdr_q <= '0;
    else if (hdr_en) hdr_q <= hdr_nx;
  end

endmodule

// File: rtl/exthdr_rx_chk.sv
module exthdr_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_tvalid,
  input logic        s_tready,
  input logic [7:0]  m_tdata,
  input logic        m_tvalid,
  input logic        m_tready,
  input logic        m_tlast,
  input logic        m_first,
  input logic [15:0] m_tpid,
  input logic        err_pulse
);

  // R8
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |-> !s_tready);

  // R8
  stall_holds_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

  // R7
  out_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> s_tvalid);

  // R7
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast) |=> !m_tvalid);

  // R7
  first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_first) |=> !m_first);

  // R5
  tpid_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tpid == 16'h8100 || m_tpid == 16'h88A8));

  // R9
  err_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !m_tvalid);

endmodule

bind exthdr_rx_parser exthdr_rx_chk i_exthdr_rx_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_tvalid  (s_tvalid),
  .s_tready  (s_tready),
  .m_tdata   (m_tdata),
  .m_tvalid  (m_tvalid),
  .m_tready  (m_tready),
  .m_tlast   (m_tlast),
  .m_first   (m_first),
  .m_tpid    (m_tpid),
  .err_pulse (err_pulse)
);

// File: tb/test_exthdr_rx_parser.sv
module test_exthdr_rx_parser;

  localparam int CLK_P = 10;

  logic        clk, rst_n;
  logic [1:0]  pfx_sel;
  logic [7:0]  s_tdata;
  logic        s_tvalid, s_tready, s_tlast;
  logic [7:0]  m_tdata;
  logic        m_tvalid, m_tready, m_tlast, m_first;
  logic [3:0]  m_src_port;
  logic [2:0]  m_qos;
  logic [15:0] m_tpid, m_tci;
  logic        err_pulse;

  int total = 0;
  int bad   = 0;

  logic [7:0] tx_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];
  int err_seen, meta_seen, tlast_at, tlast_cnt;
  int got_src, got_qos, got_tpid, got_tci;

  exthdr_rx_parser i_exthdr_rx_parser (
    .clk(clk), .rst_n(rst_n), .pfx_sel(pfx_sel),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .m_first(m_first), .m_src_port(m_src_port), .m_qos(m_qos), .m_tpid(m_tpid),
    .m_tci(m_tci), .err_pulse(err_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [223:0] mk_hdr(int src, int qos, int tag, int tci, int pop, int ofs);
    logic [223:0] v;
    v = {7{32'h5A3C_96E1}};
    v[143:140] = src[3:0];
    v[96:94]   = qos[2:0];
    v[119]     = tag[0];
    v[118:103] = tci[15:0];
    v[147:146] = pop[1:0];
    v[145:144] = ofs[1:0];
    return v;
  endfunction

  task automatic build(input int fmt, input logic [223:0] hv, input int gap, input int plen, input int seed);
    tx_q.delete();
    exp_q.delete();
    if (fmt == 2) begin
      for (int i = 0; i < 6; i++) tx_q.push_back(8'hFF);
      tx_q.push_back(8'hFE);
      for (int i = 0; i < 5; i++) tx_q.push_back(8'hFF);
    end
    if (fmt == 1 || fmt == 2) begin
      tx_q.push_back(8'h88); tx_q.push_back(8'h80);
      tx_q.push_back(8'h00); tx_q.push_back(8'h11);
    end
    for (int i = 0; i < 28; i++) tx_q.push_back(hv[223-8*i -: 8]);
    for (int i = 0; i < gap; i++) tx_q.push_back(8'hAA);
    for (int i = 0; i < plen; i++) begin
      tx_q.push_back(8'((seed + 7*i) & 8'hFF));
      exp_q.push_back(8'((seed + 7*i) & 8'hFF));
    end
    pfx_sel = fmt[1:0];
  endtask

  // drives tx_q; alt >= 0 changes pfx_sel after the first byte; cut >= 0 truncates
  task automatic drive(input int alt, input bit stall, input int cut);
    int n;
    int i;
    int cyc;
    bit pend;
    n = (cut >= 0) ? cut : tx_q.size();
    i = 0; cyc = 0; pend = 0;
    rx_q.delete();
    err_seen = 0; meta_seen = 0; tlast_at = -1; tlast_cnt = 0;
    while (i < n) begin
      @(negedge clk);
      s_tvalid = (stall && !pend) ? ((cyc % 4) != 3) : 1'b1;
      s_tdata  = tx_q[i];
      s_tlast  = (i == n - 1);
      m_tready = stall ? ((cyc % 3) != 1) : 1'b1;
      #(CLK_P/4);
      if (m_tvalid && m_tready) begin
        rx_q.push_back(m_tdata);
        if (m_first) begin
          meta_seen++;
          got_src = int'(m_src_port); got_qos = int'(m_qos);
          got_tpid = int'(m_tpid);    got_tci = int'(m_tci);
        end
        if (m_tlast) begin tlast_cnt++; tlast_at = rx_q.size(); end
      end
      pend = s_tvalid && !s_tready;
      @(posedge clk);
      #1;
      if (s_tvalid && !pend) begin
        i++;
        if (i == 1 && alt >= 0) pfx_sel = alt[1:0];
      end
      if (err_pulse) err_seen++;
      cyc++;
    end
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0; m_tready = 1'b1;
    repeat (2) begin
      @(posedge clk); #1;
      if (err_pulse) err_seen++;
    end
  endtask

  task automatic chk_payload(input string req);
    bit ok;
    int bad_i;
    ok = (rx_q.size() == exp_q.size());
    bad_i = -1;
    if (ok) for (int k = 0; k < rx_q.size(); k++) if (rx_q[k] != exp_q[k] && bad_i < 0) bad_i = k;
    chk(ok, req, "payload length", rx_q.size(), exp_q.size());
    if (ok) chk(bad_i < 0, req, "payload byte index", bad_i, -1);
  endtask

  task automatic t_reset;
    chk(s_tready == 1'b1, "R8", "reset s_tready", int'(s_tready), 1);
    chk(m_tvalid == 1'b0, "R7", "reset m_tvalid", int'(m_tvalid), 0);
    chk(err_pulse == 1'b0, "R9", "reset err_pulse", int'(err_pulse), 0);
  endtask

  task automatic t_long_ctag;
    build(2, mk_hdr(5, 6, 0, 16'h1234, 1, 2), 0, 20, 3);
    drive(-1, 0, -1);
    chk(err_seen == 0, "R2", "long prefix err", err_seen, 0);
    chk_payload("R7");
    chk(meta_seen == 1, "R7", "first beats", meta_seen, 1);
    chk(tlast_cnt == 1 && tlast_at == 20, "R7", "tlast position", tlast_at, 20);
    chk(got_src == 5, "R4", "src port", got_src, 5);
    chk(got_qos == 6, "R4", "qos", got_qos, 6);
    chk(got_tci == 16'h1234, "R4", "tci", got_tci, 16'h1234);
    chk(got_tpid == 16'h8100, "R5", "tpid ctag", got_tpid, 16'h8100);
  endtask

  task automatic t_short_stag_gap8;
    build(1, mk_hdr(10, 3, 1, 16'hE00F, 0, 0), 8, 16, 40);
    drive(-1, 0, -1);
    chk(err_seen == 0, "R3", "short prefix err", err_seen, 0);
    chk_payload("R6");
    chk(got_tpid == 16'h88A8, "R5", "tpid stag", got_tpid, 16'h88A8);
    chk(got_src == 10, "R4", "src port", got_src, 10);
    chk(got_tci == 16'hE00F, "R4", "tci", got_tci, 16'hE00F);
  endtask

  task automatic t_none_gap4_stall;
    build(0, mk_hdr(15, 7, 0, 16'h0FFE, 3, 1), 4, 30, 99);
    drive(-1, 1, -1);
    chk(err_seen == 0, "R8", "stalled frame err", err_seen, 0);
    chk_payload("R8");
    chk(meta_seen == 1 && got_qos == 7, "R4", "qos under stall", got_qos, 7);
    chk(tlast_at == 30, "R7", "tlast under stall", tlast_at, 30);
  endtask

  task automatic t_gap0_other;
    build(1, mk_hdr(2, 1, 1, 16'h0001, 2, 0), 0, 10, 7);
    drive(-1, 0, -1);
    chk_payload("R6");
  endtask

  task automatic t_bad_long;
    build(2, mk_hdr(1, 1, 0, 16'h0100, 1, 1), 0, 12, 5);
    tx_q[6] = 8'hFF;
    drive(-1, 0, -1);
    chk(err_seen == 1, "R9", "long mismatch err", err_seen, 1);
    chk(rx_q.size() == 0, "R9", "dropped output bytes", rx_q.size(), 0);
    t_long_ctag();
  endtask

  task automatic t_bad_short;
    build(1, mk_hdr(1, 1, 0, 16'h0100, 1, 1), 0, 12, 5);
    tx_q[2] = 8'h01;
    drive(-1, 0, -1);
    chk(err_seen == 1, "R3", "short mismatch err", err_seen, 1);
    chk(rx_q.size() == 0, "R9", "dropped output bytes", rx_q.size(), 0);
  endtask

  task automatic t_truncated;
    build(0, mk_hdr(4, 4, 0, 16'h4444, 1, 1), 0, 8, 1);
    drive(-1, 0, 10);
    chk(err_seen == 1, "R10", "cut in header err", err_seen, 1);
    chk(rx_q.size() == 0, "R10", "cut in header output", rx_q.size(), 0);
    build(1, mk_hdr(4, 4, 0, 16'h4444, 0, 0), 8, 8, 1);
    drive(-1, 0, 4 + 28 + 3);
    chk(err_seen == 1, "R10", "cut in gap err", err_seen, 1);
    chk(rx_q.size() == 0, "R10", "cut in gap output", rx_q.size(), 0);
    t_gap0_other();
  endtask

  task automatic t_fmt_sampling;
    build(2, mk_hdr(9, 2, 1, 16'hBEEF, 1, 3), 0, 14, 60);
    drive(0, 0, -1);
    chk(err_seen == 0, "R1", "mid-frame select change err", err_seen, 0);
    chk_payload("R1");
    build(0, mk_hdr(9, 2, 1, 16'hBEEF, 1, 3), 0, 9, 61);
    pfx_sel = 2'd3;
    drive(-1, 0, -1);
    chk(err_seen == 0, "R1", "select 3 err", err_seen, 0);
    chk_payload("R1");
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pfx_sel = 2'd0; s_tdata = 8'h00;
    s_tvalid = 1'b0; s_tlast = 1'b0; m_tready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long_ctag();
    t_short_stag_gap8();
    t_none_gap4_stall();
    t_gap0_other();
    t_bad_long();
    t_bad_short();
    t_truncated();
    t_fmt_sampling();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule